// File: doc/BRIEF.md
# Store-and-Forward Packet Gate

This block sits between a network receive MAC and the logic behind it. Beats arrive as 64 data bits, a 4-bit user sideband and an end-of-packet flag. The gate writes every beat into an internal buffer but keeps its output quiet until the whole packet has landed. It then sends that packet downstream as one unbroken burst, so the consumer spends as few cycles as possible on it.

When bit 3 of the sideband is set on the final beat, the MAC has judged the packet bad. The gate then moves its write pointer back to the last commit point. The packet disappears and none of its beats ever reach the output. Two write pointers make this work: a speculative one that advances with each beat, and a committed one that only moves at a good end of packet. The read side never passes the committed pointer. A synchronous clear and the reset each empty the buffer in one cycle.

With the default depth of 2^11 eight-byte entries, the gate holds two 8 KB packets. That is more than the roughly 9900 bytes a maximum-length frame can span, so even such a frame can be taken in whole and then dropped.

Top module: `pkt_gate`

## Requirements
- R1: After reset, or in the cycle after `clear` is high, `out_valid` is 0 and `in_ready` is 1. Any stored or partly written packets are discarded.
- R2: `out_valid` stays 0 while the only data in the buffer belongs to a packet whose final beat (`in_last`=1) has not been accepted.
- R3: A good packet comes out with the same number of beats, the same data, the same user bits and the same last flag, in arrival order. `out_valid` rises in the cycle after its final beat is accepted, if nothing is queued ahead of it.
- R4: Once the first beat of a packet is shown, `out_valid` stays 1 until that packet's last beat is taken. With `out_ready` held at 1, the packet leaves at one beat per cycle.
- R5: A packet whose final beat has `in_user[3]`=1 is never shown on the output. A packet stored after it comes out normally.
- R6: `in_user[3]`=1 on a beat that is not the last beat does not drop the packet, and the user bits are passed through unchanged.
- R7: `in_ready` is 0 while the beats written since the oldest unread beat (including beats of an unfinished packet) fill all 2^ADDR_W entries. It returns to 1 once the output drains.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_data`, `out_user` and `out_last` unchanged.
- R9: A packet's end can be committed on input in the same cycle that another packet's last beat leaves on output, and neither packet is lost or duplicated.
- R10: Dropping a bad packet frees the space it used. After a bad packet that filled the whole buffer, `in_ready` is 1 again with nothing emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous flush of all stored data |
| in_data | input | 64 | Incoming beat data |
| in_user | input | 4 | Incoming sideband; bit 3 on the last beat marks an errored packet |
| in_last | input | 1 | Final beat of the incoming packet |
| in_valid | input | 1 | Incoming beat is valid |
| in_ready | output | 1 | Gate can accept a beat |
| out_data | output | 64 | Outgoing beat data |
| out_user | output | 4 | Outgoing sideband |
| out_last | output | 1 | Final beat of the outgoing packet |
| out_valid | output | 1 | Outgoing beat is valid |
| out_ready | input | 1 | Consumer accepts the outgoing beat |

## Verification
The two functions most likely to collide are the write-side commit of a finished packet and the read-side retirement of another packet's last beat. Both change the count of complete packets, and they can land on the same clock edge. The bench stores one 4-beat packet and then streams a second 4-beat packet in while the first drains. This lines up the second packet's final write with the first packet's final read. It then expects the second packet to follow in full, and expects the output to go idle after that, with no extra or missing packet.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;

    localparam int DATA_W  = 64;
    localparam int USER_W  = 4;
    localparam int ERR_BIT = 3;

    typedef struct packed {
        logic              last;
        logic [USER_W-1:0] user;
        logic [DATA_W-1:0] data;
    } beat_t;

    localparam int BEAT_W = $bits(beat_t);

    function automatic logic beat_is_bad(beat_t b);
        return b.last && b.user[ERR_BIT];
    endfunction

    function automatic logic beat_is_good_end(beat_t b);
        return b.last && !b.user[ERR_BIT];
    endfunction

endpackage

// File: rtl/pkt_gate_store.sv
module pkt_gate_store
    import pkt_gate_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  beat_t             wr_beat,
    input  logic [ADDR_W-1:0] rd_addr,
    output beat_t             rd_beat
);
    localparam int DEPTH = 1 << ADDR_W;

    beat_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_beat;
        end
    end

    assign rd_beat = mem[rd_addr];

endmodule

// File: rtl/pkt_gate_wr.sv
module pkt_gate_wr
    import pkt_gate_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              in_valid,
    input  beat_t             in_beat,
    input  logic [ADDR_W:0]   rd_ptr,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   commit_ptr,
    output logic              pkt_commit
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [PW-1:0] spec_ptr;
    logic [PW-1:0] used;
    logic          full;
    logic          accept;

    assign used     = spec_ptr - rd_ptr;
    assign full     = (used == PW'(DEPTH));
    assign in_ready = !full;
    assign accept   = in_valid && !full;

    assign wr_en      = accept;
    assign wr_addr    = spec_ptr[ADDR_W-1:0];
    assign pkt_commit = accept && beat_is_good_end(in_beat);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            spec_ptr   <= '0;
            commit_ptr <= '0;
        end else if (accept) begin
            if (beat_is_bad(in_beat)) begin
                spec_ptr <= commit_ptr;
            end else if (in_beat.last) begin
                spec_ptr   <= spec_ptr + 1'b1;
                commit_ptr <= spec_ptr + 1'b1;
            end else begin
                spec_ptr <= spec_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pkt_gate_rd.sv
module pkt_gate_rd #(
    parameter int ADDR_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            pkt_commit,
    input  logic [ADDR_W:0] commit_ptr,
    input  logic            rd_last,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [ADDR_W:0] rd_ptr
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] pkt_cnt;
    logic          pop;
    logic          retire;

    assign out_valid = (pkt_cnt != '0) && (rd_ptr != commit_ptr);
    assign pop       = out_valid && out_ready;
    assign retire    = pop && rd_last;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pkt_cnt <= '0;
        end else begin
            unique case ({pkt_commit, retire})
                2'b10:   pkt_cnt <= pkt_cnt + 1'b1;
                2'b01:   pkt_cnt <= pkt_cnt - 1'b1;
                default: pkt_cnt <= pkt_cnt;
            endcase
        end
    end

endmodule

// File: rtl/pkt_gate.sv
module pkt_gate
    import pkt_gate_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic [63:0] in_data,
    input  logic [3:0]  in_user,
    input  logic        in_last,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [63:0] out_data,
    output logic [3:0]  out_user,
    output logic        out_last,
    output logic        out_valid,
    input  logic        out_ready
);
    beat_t             in_beat;
    beat_t             rd_beat;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W:0]   commit_ptr;
    logic [ADDR_W:0]   rd_ptr;
    logic              pkt_commit;

    assign in_beat = '{last: in_last, user: in_user, data: in_data};

    pkt_gate_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .in_valid   (in_valid),
        .in_beat    (in_beat),
        .rd_ptr     (rd_ptr),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .commit_ptr (commit_ptr),
        .pkt_commit (pkt_commit)
    );

    pkt_gate_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_beat (in_beat),
        .rd_addr (rd_ptr[ADDR_W-1:0]),
        .rd_beat (rd_beat)
    );

    pkt_gate_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .pkt_commit (pkt_commit),
        .commit_ptr (commit_ptr),
        .rd_last    (rd_beat.last),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .rd_ptr     (rd_ptr)
    );

    assign out_data = rd_beat.data;
    assign out_user = rd_beat.user;
    assign out_last = rd_beat.last;

endmodule

// File: rtl/pkt_gate_chk.sv
module pkt_gate_chk (
    input logic        clk,
    input logic        rst,
    input logic        clear,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_last,
    input logic        in_err,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data,
    input logic [3:0]  out_user,
    input logic        out_last
);
    logic in_fire;
    assign in_fire = in_valid && in_ready;

    // R1: flush leaves the gate idle and open
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!out_valid && in_ready));

    // R2: a partial packet alone never makes the output valid
    a_r2_hold_partial: assert property (@(posedge clk) disable iff (rst || clear)
        (!out_valid && in_fire && !in_last) |=> !out_valid);

    // R5: an errored end on an empty gate leaves the output idle
    a_r5_drop_bad: assert property (@(posedge clk) disable iff (rst || clear)
        (!out_valid && in_fire && in_last && in_err) |=> !out_valid);

    // R4: no gap in the middle of an outgoing packet
    a_r4_burst: assert property (@(posedge clk) disable iff (rst || clear)
        (out_valid && out_ready && !out_last) |=> out_valid);

    // R8: stalled output holds its beat
    a_r8_stable: assert property (@(posedge clk) disable iff (rst || clear)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_user) && $stable(out_last)));

endmodule

bind pkt_gate pkt_gate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .in_err    (in_user[3]),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_user  (out_user),
    .out_last  (out_last)
);

// File: tb/pkt_gate_tb.sv
module pkt_gate_tb;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear = 1'b0;
    logic [63:0] in_data = '0;
    logic [3:0]  in_user = '0;
    logic        in_last = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] out_data;
    logic [3:0]  out_user;
    logic        out_last;
    logic        out_valid;
    logic        out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pkt_gate #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .in_data   (in_data),
        .in_user   (in_user),
        .in_last   (in_last),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_user  (out_user),
        .out_last  (out_last),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    // table entry: {length[5:0], error flag, expected to emerge}
    localparam int NVEC = 9;
    localparam logic [7:0] VEC [NVEC] = '{
        {6'd1,  1'b0, 1'b1},
        {6'd3,  1'b0, 1'b1},
        {6'd5,  1'b1, 1'b0},
        {6'd2,  1'b0, 1'b1},
        {6'd12, 1'b0, 1'b1},
        {6'd16, 1'b1, 1'b0},
        {6'd16, 1'b0, 1'b1},
        {6'd1,  1'b1, 1'b0},
        {6'd10, 1'b0, 1'b1}
    };

    function automatic logic [63:0] exp_data(int seed, int i);
        return {seed[31:0], i[31:0]};
    endfunction

    function automatic logic [3:0] exp_user(int i, int len, bit err);
        if (i == len - 1) return {err, 3'b101};
        return i[3:0];
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(int len, int seed, bit err, bit chk_quiet);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = exp_data(seed, i);
            in_user  = exp_user(i, len, err);
            in_last  = (i == len - 1);
            #1;
            if (chk_quiet && i > 0)
                check(out_valid == 1'b0, "R2", "out_valid during partial packet", 64'(out_valid), 64'd0);
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic recv_pkt(int len, int seed);
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        for (int i = 0; i < len; i++) begin
            check(out_valid == 1'b1, "R4", "out_valid within burst", 64'(out_valid), 64'd1);
            check(out_data == exp_data(seed, i), "R3", "out_data", out_data, exp_data(seed, i));
            check(out_user == exp_user(i, len, 1'b0), "R6", "out_user", 64'(out_user), 64'(exp_user(i, len, 1'b0)));
            check(out_last == (i == len - 1), "R3", "out_last", 64'(out_last), 64'(i == len - 1));
            @(negedge clk);
            #1;
        end
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

        // vector table: R3, R5, R6, R10
        for (int v = 0; v < NVEC; v++) begin
            int  len;
            bit  err;
            bit  emit;
            len  = int'(VEC[v][7:2]);
            err  = VEC[v][1];
            emit = VEC[v][0];
            send_pkt(len, 100 + v, err, 1'b1);
            #1;
            if (emit) begin
                check(out_valid == 1'b1, "R3", "out_valid after last beat", 64'(out_valid), 64'd1);
                recv_pkt(len, 100 + v);
            end else begin
                repeat (3) @(negedge clk);
                #1;
                check(out_valid == 1'b0, "R5", "errored packet emitted", 64'(out_valid), 64'd0);
                check(in_ready == 1'b1, "R10", "in_ready after drop", 64'(in_ready), 64'd1);
            end
            check(out_valid == 1'b0, "R3", "idle after packet", 64'(out_valid), 64'd0);
        end

        // R8: stalled output stays stable
        send_pkt(3, 7, 1'b0, 1'b1);
        repeat (4) begin
            @(negedge clk);
            #1;
            check(out_valid == 1'b1, "R8", "out_valid held", 64'(out_valid), 64'd1);
            check(out_data == exp_data(7, 0), "R8", "out_data held", out_data, exp_data(7, 0));
        end
        recv_pkt(3, 7);

        // R7: full buffer stalls input
        send_pkt(DEPTH, 8, 1'b0, 1'b1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = exp_data(9, 0);
        in_user  = 4'h0;
        in_last  = 1'b1;
        #1;
        check(in_ready == 1'b0, "R7", "in_ready when full", 64'(in_ready), 64'd0);
        @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R7", "in_ready still full", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        in_last  = 1'b0;
        recv_pkt(DEPTH, 8);
        #1;
        check(in_ready == 1'b1, "R7", "in_ready after drain", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R7", "stalled beat not stored", 64'(out_valid), 64'd0);

        // R9: commit and retire on the same edge
        send_pkt(4, 20, 1'b0, 1'b1);
        fork
            recv_pkt(4, 20);
            send_pkt(4, 21, 1'b0, 1'b0);
        join
        #1;
        check(out_valid == 1'b1, "R9", "second packet pending", 64'(out_valid), 64'd1);
        recv_pkt(4, 21);
        check(out_valid == 1'b0, "R9", "no extra packet", 64'(out_valid), 64'd0);

        // R1: clear discards stored and partial data
        send_pkt(5, 30, 1'b0, 1'b1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = exp_data(31, 0);
        in_user  = 4'h0;
        in_last  = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        clear    = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after clear", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R1", "in_ready after clear", 64'(in_ready), 64'd1);
        send_pkt(2, 32, 1'b0, 1'b1);
        recv_pkt(2, 32);
        check(out_valid == 1'b0, "R1", "only new packet after clear", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule